// File: doc/BRIEF.md
# Stereo Soft Mute with Bit-Clock Loss Guard

This block sits on a stereo sample stream between the serial audio receiver and the DAC datapath, and scales both channels by one shared gain. An active-low mute pin asks for silence. While mute is in force, the gain falls in equal steps, one step per sample strobe, and reaches zero after a fixed count of samples. When mute is lifted, the gain goes back to unity on the very next sample. This holds even if the ramp has not yet finished.

A watchdog tracks activity on the bit clock, delivered as a one-cycle edge pulse in the system clock domain. If it stays silent too long, the block mutes by itself. The forced mute ends once edges have been present across one whole frame, counted from one sample strobe to the next. After reset the block counts the clock as lost and the gain as zero, so the output starts silent.

Top module: `soft_mute_ctrl`

## Requirements
- R1: `mute_n` low requests mute and high means normal play. The pin passes through two flip-flops, so a strobe that arrives together with a pin change still uses the old level.
- R2: Both channels share one gain value in every sample.
- R3: Let k count the strobes since mute took effect. The k-th strobe uses gain g = max(0, 65536 - 82*k) on a unity of 65536. Each output is floor(sample*g/65536). The gain is nonzero at k = 799 and first reaches zero at k = 800.
- R4: The first strobe after mute is released uses unity gain, so the outputs equal the inputs exactly. This holds when release happens in the middle of a ramp.
- R5: Once the gain reaches zero, every output sample is exactly zero until mute is released.
- R6: If 256 system clock cycles pass with no `bclk_edge` pulse, the block forces mute. A gap of 200 cycles does not.
- R7: After edges come back, the forced mute ends at the second sample strobe seen with edges present. The strobe that follows uses unity gain.
- R8: After reset, `out_vld` is low, the outputs are zero and the gain is zero. Strobes keep producing zero output until the R7 recovery completes.
- R9: `out_vld` pulses exactly one cycle after each `smp_vld`, and the output samples hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute_n | input | 1 | Mute request pin, low mutes (asynchronous) |
| bclk_edge | input | 1 | One-cycle pulse for each detected bit clock edge |
| smp_vld | input | 1 | Sample strobe for the stereo pair |
| smp_l | input | SAMPLE_W | Left sample, two's complement |
| smp_r | input | SAMPLE_W | Right sample, two's complement |
| out_vld | output | 1 | Scaled sample valid |
| out_l | output | SAMPLE_W | Scaled left sample |
| out_r | output | SAMPLE_W | Scaled right sample |

## Verification
A gain register that is off by a single step shows up within one sample, because full-scale inputs turn every gain unit into output codes. A wrong step size or a wrong end count shows up at the end of the ramp: output is still nonzero at strobe 800, or already zero at strobe 799. A fault in the release path leaves the first sample after release differing from its input. A fault in the clock watchdog shifts when the automatic ramp starts, or how many strobes the recovery takes, and both can be seen within a few samples.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // gain decrement per strobe so that RAMP_LEN strobes cover unity
  function automatic int unsigned ramp_step(int unsigned gain_w, int unsigned ramp_len);
    return ((32'd1 << gain_w) + ramp_len - 1) / ramp_len;
  endfunction

  typedef enum logic [1:0] {
    MON_OK      = 2'd0,
    MON_LOST    = 2'd1,
    MON_ARMED   = 2'd2
  } mon_state_t;
endpackage

// File: rtl/sm_sync2.sv
module sm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      q_sync <= 1'b1;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/sm_bclk_watch.sv
module sm_bclk_watch
  import sm_pkg::*;
#(
  parameter int unsigned LOSS_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_edge,
  input  logic strobe,
  output logic clk_lost
);
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

  logic [CW-1:0] idle_q;
  mon_state_t    st_q;
  logic          starve;

  assign starve   = (idle_q == LIMIT);
  assign clk_lost = (st_q != MON_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (bclk_edge) begin
      idle_q <= '0;
    end else if (!starve) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MON_LOST;
    end else if (starve) begin
      st_q <= MON_LOST;
    end else if (strobe) begin
      case (st_q)
        MON_LOST:  st_q <= MON_ARMED;
        MON_ARMED: st_q <= MON_OK;
        default:   st_q <= MON_OK;
      endcase
    end
  end

  a_r6_starve_forces_loss: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> clk_lost);

  a_r7_clear_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lost && !strobe) |=> clk_lost);
endmodule

// File: rtl/sm_gain_step.sv
module sm_gain_step
  import sm_pkg::*;
#(
  parameter int unsigned GAIN_W   = 16,
  parameter int unsigned RAMP_LEN = 800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            mute_eff,
  output logic [GAIN_W:0] gain_next,
  output logic [GAIN_W:0] gain_q
);
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;
  localparam logic [GAIN_W:0] STEP  = (GAIN_W+1)'(ramp_step(GAIN_W, RAMP_LEN));

  always_comb begin
    if (!mute_eff)
      gain_next = UNITY;
    else if (gain_q > STEP)
      gain_next = gain_q - STEP;
    else
      gain_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gain_q <= '0;
    else if (strobe)
      gain_q <= gain_next;
  end

  a_r4_release_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !mute_eff) |=> (gain_q == UNITY));

  a_r3_ramp_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mute_eff) |=> (gain_q <= $past(gain_q)));

  a_r9_gain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(gain_q));
endmodule

// File: rtl/sm_scale_ch.sv
module sm_scale_ch #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned GAIN_W   = 16
) (
  input  logic signed [SAMPLE_W-1:0] din,
  input  logic        [GAIN_W:0]     gain,
  output logic signed [SAMPLE_W-1:0] dout
);
  localparam int unsigned PW = SAMPLE_W + GAIN_W + 2;

  function automatic logic signed [SAMPLE_W-1:0] apply_gain(
    input logic signed [SAMPLE_W-1:0] s,
    input logic        [GAIN_W:0]     g
  );
    logic signed [PW-1:0] p;
    p = PW'(s) * $signed(PW'({1'b0, g}));
    return p[GAIN_W +: SAMPLE_W];
  endfunction

  assign dout = apply_gain(din, gain);
endmodule

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl #(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned GAIN_W      = 16,
  parameter int unsigned RAMP_LEN    = 800,
  parameter int unsigned LOSS_CYCLES = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mute_n,
  input  logic                       bclk_edge,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_l,
  input  logic signed [SAMPLE_W-1:0] smp_r,
  output logic                       out_vld,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r
);
  localparam int unsigned NCH = 2;

  logic              mute_n_s;
  logic              clk_lost;
  logic              mute_eff;
  logic [GAIN_W:0]   gain_next;
  logic [GAIN_W:0]   gain_q;
  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  sm_sync2 u_mute_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (mute_n),
    .q_sync  (mute_n_s)
  );

  sm_bclk_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_edge (bclk_edge),
    .strobe    (smp_vld),
    .clk_lost  (clk_lost)
  );

  assign mute_eff = !mute_n_s || clk_lost;

  sm_gain_step #(.GAIN_W(GAIN_W), .RAMP_LEN(RAMP_LEN)) u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (smp_vld),
    .mute_eff  (mute_eff),
    .gain_next (gain_next),
    .gain_q    (gain_q)
  );

  assign ch_in[0] = smp_l;
  assign ch_in[1] = smp_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sm_scale_ch #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
      .din  (ch_in[c]),
      .gain (gain_next),
      .dout (ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        out_l <= ch_out[0];
        out_r <= ch_out[1];
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!out_vld && $stable(out_l) && $stable(out_r)));

  a_r5_zero_gain_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && gain_q == '0) |-> (out_l == '0 && out_r == '0));

  a_r4_unity_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !mute_eff) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));

  a_r1_mute_gates_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !mute_n_s && gain_q == '0) |=> (gain_q == '0));
endmodule

// File: tb/soft_mute_ctrl_tb.sv
module soft_mute_ctrl_tb;
  localparam int SW = 24;
  localparam longint UNITY = 65536;
  localparam longint STEP  = 82;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute_n = 1'b1;
  logic bclk_edge = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [SW-1:0] smp_l = '0;
  logic signed [SW-1:0] smp_r = '0;
  logic out_vld;
  logic signed [SW-1:0] out_l;
  logic signed [SW-1:0] out_r;

  int n_chk = 0;
  int n_bad = 0;
  bit bclk_on = 1'b0;
  int edge_cnt = 0;

  always #5 clk = ~clk;

  soft_mute_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .bclk_edge(bclk_edge),
    .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r)
  );

  always @(negedge clk) begin
    edge_cnt <= edge_cnt + 1;
    bclk_edge <= bclk_on && (edge_cnt % 4 == 0);
  end

  function automatic longint scaled(input logic signed [SW-1:0] s, input longint g);
    longint p;
    p = longint'(s) * g;
    return p >>> 16;
  endfunction

  function automatic logic signed [SW-1:0] pat(input int i);
    if (i % 5 == 0) return 24'sh7FFFFF;
    if (i % 5 == 1) return 24'sh800000;
    return SW'((i * 104729 + 7919) & 32'hFFFFFF);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobe, then check both channels against gain g
  task automatic strobe(input string req, input int i, input longint g);
    smp_l   = pat(i);
    smp_r   = pat(i + 3);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check({req, " left"},  longint'(out_l), scaled(pat(i), g));
    check({req, " right"}, longint'(out_r), scaled(pat(i + 3), g));
    @(negedge clk);
  endtask

  function automatic longint ramp_g(input int k);
    longint v;
    v = UNITY - STEP * k;
    return (v < 0) ? 0 : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 out_vld", longint'(out_vld), 0);
    check("R8 out_l", longint'(out_l), 0);
    check("R8 out_r", longint'(out_r), 0);
    rst_n = 1'b1;
    bclk_on = 1'b1;
    repeat (6) @(negedge clk);

    // R8/R7: two strobes still silent, third at unity
    strobe("R8 startup arm", 0, 0);
    strobe("R8 startup clear", 1, 0);
    strobe("R7 startup unity", 2, UNITY);

    // R9 valid pulse shape
    smp_vld = 1'b1; smp_l = pat(7); smp_r = pat(10);
    @(negedge clk);
    smp_vld = 1'b0;
    check("R9 out_vld high", longint'(out_vld), 1);
    @(negedge clk);
    check("R9 out_vld low", longint'(out_vld), 0);
    repeat (3) @(negedge clk);
    check("R9 hold", longint'(out_l), longint'(pat(7)));

    // R4/R2 unity sweep
    for (int i = 0; i < 40; i++) strobe("R2 unity sweep", i, UNITY);

    // R1: strobe on the same edge as the pin change still sees old level
    mute_n = 1'b0;
    strobe("R1 sync latency", 11, UNITY);
    @(negedge clk);

    // R3 full ramp, R5 hold at zero
    for (int k = 1; k <= 815; k++) begin
      if (k <= 800) strobe("R3 ramp", k, ramp_g(k));
      else          strobe("R5 zero hold", k, 0);
      if (k == 799) check("R3 gain nonzero at 799", (out_l != 0) ? 1 : 0, 1);
    end

    // R4 release after complete ramp
    mute_n = 1'b1;
    repeat (3) @(negedge clk);
    strobe("R4 release", 20, UNITY);

    // R4 release mid-ramp
    mute_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 1; k <= 100; k++) strobe("R3 partial ramp", k + 50, ramp_g(k));
    mute_n = 1'b1;
    repeat (3) @(negedge clk);
    strobe("R4 mid-ramp release", 30, UNITY);

    // R6: short gap does not mute
    bclk_on = 1'b0;
    repeat (200) @(negedge clk);
    strobe("R6 short gap", 31, UNITY);
    bclk_on = 1'b1;
    repeat (8) @(negedge clk);

    // R6: long gap mutes
    bclk_on = 1'b0;
    repeat (300) @(negedge clk);
    strobe("R6 loss ramp", 35, ramp_g(1));
    strobe("R6 loss ramp", 36, ramp_g(2));

    // R7 recovery
    bclk_on = 1'b1;
    repeat (8) @(negedge clk);
    strobe("R7 arm", 40, ramp_g(3));
    strobe("R7 clear", 41, ramp_g(4));
    strobe("R7 unity", 42, UNITY);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule